// File: doc/BRIEF.md
# Stuck-at Fault Coverage Sweeper

This block characterises a small gate-level circuit under test whose final gate changes function under a mode select. The gate is NAND in one mode and NOR in the other. The circuit is a one-bit full adder built so that its carry output is the same in both modes when no fault is present. The carry is formed twice by two independent gate networks, and the mode-controlled gate merges the two results. Any fault that makes the two halves disagree makes the carry toggle when the mode flips.

The sweeper works through the gates in order. For each gate it forces the gate output to 0 and then to 1. For each forced value it applies all input combinations, first in NAND mode and then in NOR mode, and samples the carry one clock after each setting changes. It then stores the XOR of the two response words as a coverage bitmap with one bit per input vector. The bitmaps are read through a registered address/data port. When the sweep ends, a one-cycle done pulse fires, a per-gate mask names the gates where a forced value gave no toggling, and an all-covered flag reports whether that mask is empty.

Top module: `stuck_fault_sweeper`

## Requirements
- R1: After reset, `done`, `all_covered` and `uncovered_gates` are all zero.
- R2: The circuit under test is built from gates k1 to k7 over inputs a, b and c. The gates are: k1 = a^b; k2 = k1^c; k3 = ~(a&b); k4 = ~(c&k1); k5 = k3&k4; k6 = k1 ? k2 : ~a; and k7 = NAND(k5,k6) in mode 0 or NOR(k5,k6) in mode 1. The observed output is k7. With no fault, k5 equals k6.
- R3: Coverage word address 2*(g-1)+p holds the result for gate g stuck at p (p = 0 means stuck-at-0). Bit i of the word is 1 exactly when the observed output for input vector i differs between mode 0 and mode 1. Vector index i has bit 0 = a, bit 1 = b and bit 2 = c.
- R4: `rd_data` shows the word at `rd_addr` sampled at the previous rising clock edge.
- R5: `done` is high for exactly one cycle. It rises 4*SWEEP_GATES*8 clock edges after the edge that captured `start`.
- R6: A `start` that arrives while a sweep is running is ignored. The running sweep keeps its timing and its results.
- R7: After a sweep, bit g-1 of `uncovered_gates` is 1 exactly when either coverage word of gate g is all zero.
- R8: `all_covered` is 1 after a sweep exactly when `uncovered_gates` is zero.
- R9: A `start` accepted while idle clears `uncovered_gates` and `all_covered` on the capturing edge.
- R10: Parameter SWEEP_GATES limits the sweep to gates 1 to SWEEP_GATES. With 6, the output gate is skipped and every swept gate is covered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sweep when idle |
| rd_addr | input | AW | Coverage word address, 2*(gate-1)+polarity |
| rd_data | output | 8 | Coverage word, one cycle after the address |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| all_covered | output | 1 | No swept gate has an empty coverage word |
| uncovered_gates | output | SWEEP_GATES | Per-gate empty-word mask |

## Verification
Two functions can fall in the same cycle: a sweep in progress and a new start request, and the final coverage write together with the flag update and the done pulse. The bench raises `start` in the middle of a running sweep. It then judges the run by the unchanged done latency and by reading back every coverage word against values worked out by hand from the gate equations. On the last edge the same data feeds the empty mask and the all-covered flag, so both are checked in the cycle done is seen. A shortened sweep exercises the case where every flag is clear.

// File: rtl/swp_pkg.sv
package swp_pkg;
  // Circuit under test dimensions.
  localparam int CUT_GATES  = 7;
  localparam int CUT_INPUTS = 3;
  localparam int CUT_VECS   = 1 << CUT_INPUTS;
  localparam int GATE_IDW   = $clog2(CUT_GATES + 1);

  typedef logic [CUT_VECS-1:0]   cov_word_t;
  typedef logic [CUT_INPUTS-1:0] vec_idx_t;

  // Fault setting applied to the circuit under test.
  typedef struct packed {
    logic                enable;
    logic [GATE_IDW-1:0] gate;
    logic                value;
  } fault_cfg_t;
endpackage

// File: rtl/swp_dut_circuit.sv
module swp_dut_circuit
  import swp_pkg::*;
(
  input  vec_idx_t   vec,
  input  logic       mode,
  input  fault_cfg_t fault,
  output logic       obs
);
  logic a, b, c;
  logic r1, r2, r3, r4, r5, r6, r7;
  logic n1, n2, n3, n4, n5, n6, n7;

  assign a = vec[0];
  assign b = vec[1];
  assign c = vec[2];

  // Replace a gate output by the forced value when it is the selected gate.
  function automatic logic force_net(input logic raw, input fault_cfg_t f,
                                     input logic [GATE_IDW-1:0] id);
    return (f.enable && (f.gate == id)) ? f.value : raw;
  endfunction

  // First half: carry complement from the propagate term.
  assign r1 = a ^ b;
  assign n1 = force_net(r1, fault, GATE_IDW'(1));
  assign r2 = n1 ^ c;
  assign n2 = force_net(r2, fault, GATE_IDW'(2));
  assign r3 = ~(a & b);
  assign n3 = force_net(r3, fault, GATE_IDW'(3));
  assign r4 = ~(c & n1);
  assign n4 = force_net(r4, fault, GATE_IDW'(4));
  assign r5 = n3 & n4;
  assign n5 = force_net(r5, fault, GATE_IDW'(5));

  // Second half: carry complement selected from the sum.
  assign r6 = n1 ? n2 : ~a;
  assign n6 = force_net(r6, fault, GATE_IDW'(6));

  // Mode-controlled merge gate: NAND in mode 0, NOR in mode 1.
  assign r7 = mode ? ~(n5 | n6) : ~(n5 & n6);
  assign n7 = force_net(r7, fault, GATE_IDW'(7));

  assign obs = n7;

  // R2: with no fault the two halves must agree.
  always_comb begin
    if (!fault.enable) begin
      a_r2_halves_agree: assert (n5 == n6)
        else $error("carry halves disagree without a fault");
    end
  end
endmodule

// File: rtl/swp_bitmap_ram.sv
module swp_bitmap_ram #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int WORDS = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Registered read for block RAM inference.
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

  // R3: writes only land on swept gate/polarity slots.
  a_r3_write_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < WORDS))
    else $error("coverage write outside swept range");
endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer
  import swp_pkg::*;
#(
  parameter int SWEEP_GATES = CUT_GATES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   obs,
  output vec_idx_t               cut_vec,
  output logic                   cut_mode,
  output fault_cfg_t             cut_fault,
  output logic                   wr_en,
  output logic [GIW:0]           wr_addr,
  output cov_word_t              wr_data,
  output logic                   done,
  output logic                   all_covered,
  output logic [SWEEP_GATES-1:0] uncovered
);
  localparam int GIW = (SWEEP_GATES > 1) ? $clog2(SWEEP_GATES) : 1;
  localparam int NV  = CUT_VECS;

  logic                   busy_q;
  logic [GIW-1:0]         gate_q;
  logic                   pol_q;
  logic                   mode_q;
  vec_idx_t               vec_q;
  cov_word_t              r1_q, r2_q, r1_nxt, r2_nxt, word;
  logic                   done_q, allcov_q;
  logic [SWEEP_GATES-1:0] unc_q, unc_nxt;
  logic                   vec_last, finish, wr;

  assign vec_last = (vec_q == vec_idx_t'(NV - 1));
  assign wr       = busy_q && mode_q && vec_last;
  assign finish   = wr && pol_q && (gate_q == GIW'(SWEEP_GATES - 1));

  // Fold the current sample into the response word of the active mode.
  always_comb begin
    r1_nxt = r1_q;
    r2_nxt = r2_q;
    if (!mode_q) begin
      r1_nxt[vec_q] = obs;
    end else begin
      r2_nxt[vec_q] = obs;
    end
  end

  assign word = r1_q ^ r2_nxt;

  always_comb begin
    unc_nxt = unc_q;
    if (wr && (word == '0)) begin
      unc_nxt[gate_q] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      gate_q   <= '0;
      pol_q    <= 1'b0;
      mode_q   <= 1'b0;
      vec_q    <= '0;
      r1_q     <= '0;
      r2_q     <= '0;
      done_q   <= 1'b0;
      allcov_q <= 1'b0;
      unc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q   <= 1'b1;
          gate_q   <= '0;
          pol_q    <= 1'b0;
          mode_q   <= 1'b0;
          vec_q    <= '0;
          unc_q    <= '0;
          allcov_q <= 1'b0;
        end
      end else begin
        r1_q  <= r1_nxt;
        r2_q  <= r2_nxt;
        vec_q <= vec_q + 1'b1;
        if (vec_last) begin
          mode_q <= ~mode_q;
          if (mode_q) begin
            pol_q <= ~pol_q;
            unc_q <= unc_nxt;
            if (pol_q) begin
              gate_q <= gate_q + 1'b1;
            end
            if (finish) begin
              busy_q   <= 1'b0;
              done_q   <= 1'b1;
              allcov_q <= (unc_nxt == '0);
            end
          end
        end
      end
    end
  end

  assign cut_vec          = vec_q;
  assign cut_mode         = mode_q;
  assign cut_fault.enable = busy_q;
  assign cut_fault.gate   = GATE_IDW'(gate_q) + GATE_IDW'(1);
  assign cut_fault.value  = pol_q;
  assign wr_en            = wr;
  assign wr_addr          = {gate_q, pol_q};
  assign wr_data          = word;
  assign done             = done_q;
  assign all_covered      = allcov_q;
  assign uncovered        = unc_q;

  // R5: done is a single-cycle pulse.
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q)
    else $error("done held longer than one cycle");

  // R5: a sweep only begins from a start request.
  a_r5_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start))
    else $error("sweep began without start");

  // R6: a start during a sweep does not restart the vector count.
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && !finish) |=> (vec_q == vec_idx_t'($past(vec_q) + 1'b1)))
    else $error("start disturbed a running sweep");

  // R8: the flag and the mask agree when done fires.
  a_r8_flag_matches_mask: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (allcov_q == (unc_q == '0)))
    else $error("all_covered disagrees with uncovered mask");

  // R5: the sweep is over once done fires.
  a_r5_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q)
    else $error("still sweeping while done is high");
endmodule

// File: rtl/stuck_fault_sweeper.sv
module stuck_fault_sweeper
  import swp_pkg::*;
#(
  parameter int SWEEP_GATES = CUT_GATES,
  parameter int GIW = (SWEEP_GATES > 1) ? $clog2(SWEEP_GATES) : 1,
  parameter int AW  = GIW + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [AW-1:0]          rd_addr,
  output logic [CUT_VECS-1:0]    rd_data,
  output logic                   done,
  output logic                   all_covered,
  output logic [SWEEP_GATES-1:0] uncovered_gates
);
  vec_idx_t   cut_vec;
  logic       cut_mode;
  fault_cfg_t cut_fault;
  logic       cut_obs;
  logic       wr_en;
  logic [AW-1:0] wr_addr;
  cov_word_t  wr_data;

  // CUT inputs come from registers, so obs is sampled one cycle later.
  swp_dut_circuit u_cut (
    .vec   (cut_vec),
    .mode  (cut_mode),
    .fault (cut_fault),
    .obs   (cut_obs)
  );

  swp_sequencer #(
    .SWEEP_GATES (SWEEP_GATES)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .obs         (cut_obs),
    .cut_vec     (cut_vec),
    .cut_mode    (cut_mode),
    .cut_fault   (cut_fault),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .done        (done),
    .all_covered (all_covered),
    .uncovered   (uncovered_gates)
  );

  swp_bitmap_ram #(
    .AW    (AW),
    .DW    (CUT_VECS),
    .WORDS (2 * SWEEP_GATES)
  ) u_ram (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: tb/test_stuck_fault_sweeper.sv
module test_stuck_fault_sweeper;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_FULL   = 4 * 7 * 8 + 1;
  localparam int LAT_SHORT  = 4 * 6 * 8 + 1;

  // {address, expected coverage word}, worked out from the R2 netlist.
  localparam logic [11:0] EXPECT [14] = '{
    {4'd0,  8'h22}, {4'd1,  8'h08}, {4'd2,  8'h06}, {4'd3,  8'h60},
    {4'd4,  8'h17}, {4'd5,  8'h88}, {4'd6,  8'h17}, {4'd7,  8'h60},
    {4'd8,  8'h17}, {4'd9,  8'hE8}, {4'd10, 8'h17}, {4'd11, 8'hE8},
    {4'd12, 8'h00}, {4'd13, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, start_s = 1'b0;
  logic [3:0] rd_addr = '0, rd_addr_s = '0;
  logic [7:0] rd_data, rd_data_s;
  logic       done, done_s, all_covered, all_covered_s;
  logic [6:0] uncovered_gates;
  logic [5:0] uncovered_s;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stuck_fault_sweeper i_stuck_fault_sweeper (
    .clk (clk), .rst (rst), .start (start), .rd_addr (rd_addr),
    .rd_data (rd_data), .done (done), .all_covered (all_covered),
    .uncovered_gates (uncovered_gates)
  );

  stuck_fault_sweeper #(.SWEEP_GATES (6)) i_stuck_fault_sweeper_short (
    .clk (clk), .rst (rst), .start (start_s), .rd_addr (rd_addr_s),
    .rd_data (rd_data_s), .done (done_s), .all_covered (all_covered_s),
    .uncovered_gates (uncovered_s)
  );

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  // Run a sweep and return the edge count to done. The first edge is the one
  // that captures start. An optional second start is raised mid-sweep.
  task automatic run_sweep(input bit short_inst, input int extra_at,
                           input bit check_clear, output int lat);
    lat = 0;
    @(negedge clk);
    if (short_inst) start_s = 1'b1; else start = 1'b1;
    while (lat < 2000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start   = 1'b0;
      start_s = 1'b0;
      if (lat == 1 && check_clear) begin
        if (short_inst) begin
          check("R9 all_covered cleared on start", 32'(all_covered_s), 32'd0);
          check("R9 mask cleared on start", 32'(uncovered_s), 32'd0);
        end else begin
          check("R9 mask cleared on start", 32'(uncovered_gates), 32'd0);
        end
      end
      if (lat == extra_at) begin
        if (short_inst) start_s = 1'b1; else start = 1'b1;
      end
      if (short_inst ? done_s : done) break;
    end
  endtask

  task automatic read_word(input logic [3:0] addr, output logic [7:0] data);
    @(negedge clk);
    rd_addr = addr;
    @(negedge clk);
    data = rd_data;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int lat;
    logic [7:0] w;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state.
    check("R1 done", 32'(done), 32'd0);
    check("R1 all_covered", 32'(all_covered), 32'd0);
    check("R1 uncovered_gates", 32'(uncovered_gates), 32'd0);

    // R5, R6: full sweep with a second start in the middle.
    run_sweep(1'b0, 50, 1'b0, lat);
    check("R5 R6 done latency", 32'(lat), 32'(LAT_FULL));
    check("R7 empty mask marks output gate", 32'(uncovered_gates), 32'h40);
    check("R8 all_covered low", 32'(all_covered), 32'd0);
    @(negedge clk);
    check("R5 done single cycle", 32'(done), 32'd0);

    // R2, R3, R4: table walk over every coverage word.
    foreach (EXPECT[i]) begin
      read_word(EXPECT[i][11:8], w);
      check($sformatf("R3 word at %0d", EXPECT[i][11:8]), 32'(w), 32'(EXPECT[i][7:0]));
    end

    // R4: the new address takes effect on the next edge only.
    @(negedge clk);
    rd_addr = 4'd3;
    @(negedge clk);
    rd_addr = 4'd0;
    #1;
    check("R4 read latency", 32'(rd_data), 32'h60);
    @(negedge clk);
    check("R4 read after update", 32'(rd_data), 32'h22);

    // R9: a second sweep clears the mask at the start edge; results repeat.
    run_sweep(1'b0, 0, 1'b1, lat);
    check("R5 repeat latency", 32'(lat), 32'(LAT_FULL));
    check("R7 repeat mask", 32'(uncovered_gates), 32'h40);
    read_word(4'd9, w);
    check("R3 repeat word 9", 32'(w), 32'hE8);

    // R10: shortened sweep covers every swept gate.
    run_sweep(1'b1, 0, 1'b0, lat);
    check("R10 short latency", 32'(lat), 32'(LAT_SHORT));
    check("R10 short mask", 32'(uncovered_s), 32'd0);
    check("R8 short all_covered", 32'(all_covered_s), 32'd1);
    @(negedge clk);
    rd_addr_s = 4'd11;
    @(negedge clk);
    check("R10 short word 11", 32'(rd_data_s), 32'hE8);

    // R9: restarting clears all_covered.
    run_sweep(1'b1, 0, 1'b1, lat);
    check("R8 short all_covered again", 32'(all_covered_s), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule